// File: doc/BRIEF.md
# Octal Card-Image ROM Loader

This block turns a stream of ASCII card records into a byte-wide ROM image. Characters arrive one at a time on a valid/ready byte interface. A line feed ends each card. The first four cards are header cards. The rest are data cards, and each one carries a four-digit octal start address and sixteen three-digit octal words. Every decoded word is written to a 2048 x 8 memory port. Words from one card land at consecutive addresses, starting at the card's address.

Two header fields are read from the headers. The first is a code for each of three chip-select inputs: active low, active high or don't-care. The second is a logic-sense letter. When that letter selects negative logic, every stored byte is the bitwise inverse of its decoded value. A sticky error flag reports malformed records, and once it is set no further writes take place. After the last data card a done flag rises, and from then on the select codes and the logic sense are shown on stable outputs.

Top module: `romcard_loader`

## Requirements
- R1: After reset, in_ready is 1 and wr_en, done, err, all three select codes and neg_logic are 0.
- R2: A line feed (0x0A) ends a card. Columns are numbered from 1 and start again at 1 after each line feed. The first four cards are headers and every later card is a data card.
- R3: Columns 1 to 4 of a data card hold the start address as octal digits, most significant first. If that address is not a multiple of 16, or is 2048 or more, err is set.
- R4: Columns 5 to 52 of a data card hold 16 words, each three octal digits with the most significant first. Word k is written to start address + k. wr_en is high for exactly one cycle: the cycle after the clock edge that accepts the word's third digit.
- R5: in_ready is low in each write cycle and high in every other cycle.
- R6: Any of the following sets err and suppresses that write: a character other than '0' to '7' in columns 1 to 52 of a data card, or a word whose value is above octal 377.
- R7: err stays set until reset. While err is set, wr_en never rises.
- R8: A line feed on a data card before column 53 sets err. Characters in column 53 or later of a data card are ignored.
- R9: On the third header card, columns 33, 35 and 37 give the codes for selects one, two and three. '0' means active low (code 00), '1' means active high (01) and '2' means don't-care (10). Any other character in those columns sets err.
- R10: Column 15 of the fourth header card holds the logic sense. 'P' means positive, so bytes are stored as decoded. 'N' means negative, so each byte is stored inverted. Any other character sets err.
- R11: done rises on the clock edge that accepts the line feed ending the 128th data card, and then stays high. sel1_code, sel2_code, sel3_code and neg_logic read 0 until done and show the captured header values after it. After done, input bytes are still accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | ASCII input character |
| in_ready | output | 1 | Loader can take a byte this cycle |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 11 | Memory write address |
| wr_data | output | 8 | Memory write data, after the logic-sense inversion |
| done | output | 1 | All data cards have been consumed |
| err | output | 1 | Sticky format error |
| sel1_code | output | 2 | Select one code: 00 low, 01 high, 10 don't-care |
| sel2_code | output | 2 | Select two code |
| sel3_code | output | 2 | Select three code |
| neg_logic | output | 1 | 1 when negative logic was selected |

## Verification
A column counter that drifts by even one position shifts every digit of a card. The first write then carries a wrong address or a wrong value, within about seven characters of the first data card. A word index that fails to advance or to clear shows as repeated or misplaced write addresses on the second write of a card. A header card count that is off makes data records be parsed as headers, or the reverse, so whole cards of writes go missing and done rises at the wrong line feed. A lost or wrongly set error state appears at once as missing or extra writes after the bad character.

// File: rtl/romcard_pkg.sv
// Shared types and character decoders for the card-image ROM loader.
// Assumes 8-bit ASCII input.
package romcard_pkg;

    localparam logic [7:0] CH_LF = 8'h0A;

    // Result of decoding one character as an octal digit
    typedef struct packed {
        logic       ok;
        logic [2:0] val;
    } oct_t;

    // Select code encodings; 2'b11 marks an illegal character
    typedef enum logic [1:0] {
        SEL_LOW  = 2'b00,
        SEL_HIGH = 2'b01,
        SEL_ANY  = 2'b10,
        SEL_BAD  = 2'b11
    } sel_code_t;

    // Decode an ASCII octal digit
    function automatic oct_t oct_decode(input logic [7:0] c);
        oct_t r;
        r.ok  = (c >= 8'h30) && (c <= 8'h37);
        r.val = c[2:0];
        return r;
    endfunction

    // Decode a select-polarity character '0', '1' or '2'
    function automatic sel_code_t sel_decode(input logic [7:0] c);
        sel_code_t r;
        if ((c >= 8'h30) && (c <= 8'h32)) r = sel_code_t'(c[1:0]);
        else                              r = SEL_BAD;
        return r;
    endfunction

endpackage

// File: rtl/romcard_track.sv
// Column and card tracker. The column counts from 1 and saturates at its
// maximum; a line feed resets it and advances the card count. Assumes the
// caller raises step only for accepted bytes while the load is not done.
module romcard_track #(
    parameter int COL_W       = 7,
    parameter int HDR_CARDS   = 4,
    parameter int TOTAL_CARDS = 132,
    localparam int CARD_W     = $clog2(TOTAL_CARDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              is_lf,
    output logic [COL_W-1:0]  col,
    output logic [CARD_W-1:0] card,
    output logic              data_card,
    output logic              all_done
);

    localparam logic [COL_W-1:0]  COL_MAX  = '1;
    localparam logic [CARD_W-1:0] HDR_LAST = CARD_W'(HDR_CARDS);
    localparam logic [CARD_W-1:0] END_CARD = CARD_W'(TOTAL_CARDS);

    // Advance the column per byte, and the card per line feed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col  <= COL_W'(1);
            card <= '0;
        end else if (step) begin
            if (is_lf) begin
                col  <= COL_W'(1);
                card <= card + 1'b1;
            end else if (col != COL_MAX) begin
                col <= col + 1'b1;
            end
        end
    end

    assign data_card = (card >= HDR_LAST);
    assign all_done  = (card == END_CARD);

    // R11: once every card is consumed, done stays high
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> all_done)
        else $error("done dropped after completion");

endmodule

// File: rtl/romcard_hdr.sv
// Header field capture. On the select card it reads one select code per
// select column; on the logic card it reads the logic-sense letter.
// Illegal characters in those columns raise a one-cycle error pulse.
// Assumes col and card describe the byte currently being accepted.
module romcard_hdr #(
    parameter int COL_W      = 7,
    parameter int CARD_W     = 8,
    parameter int NSEL       = 3,
    parameter int SEL_CARD   = 3,
    parameter int SEL_COL0   = 33,
    parameter int SEL_STEP   = 2,
    parameter int LOGIC_CARD = 4,
    parameter int LOGIC_COL  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 is_lf,
    input  logic [7:0]           ch,
    input  logic [COL_W-1:0]     col,
    input  logic [CARD_W-1:0]    card,
    output logic [NSEL-1:0][1:0] sel_codes,
    output logic                 neg,
    output logic                 hdr_err
);
    import romcard_pkg::*;

    localparam logic [CARD_W-1:0] SCARD = CARD_W'(SEL_CARD - 1);
    localparam logic [CARD_W-1:0] LCARD = CARD_W'(LOGIC_CARD - 1);
    localparam logic [COL_W-1:0]  LCOL  = COL_W'(LOGIC_COL);

    sel_code_t       sel_val;
    logic [NSEL-1:0] sel_hit;
    logic [NSEL-1:0] sel_bad;
    logic            logic_hit;
    logic            logic_bad;

    assign sel_val = sel_decode(ch);

    // One column comparator per select input
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        localparam logic [COL_W-1:0] SCOL = COL_W'(SEL_COL0 + i * SEL_STEP);
        assign sel_hit[i] = step && !is_lf && (card == SCARD) && (col == SCOL);
        assign sel_bad[i] = sel_hit[i] && (sel_val == SEL_BAD);
    end

    assign logic_hit = step && !is_lf && (card == LCARD) && (col == LCOL);
    assign logic_bad = logic_hit && (ch != "P") && (ch != "N");
    assign hdr_err   = (|sel_bad) || logic_bad;

    // Capture legal select codes and the logic-sense letter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_codes <= {NSEL{SEL_ANY}};
            neg       <= 1'b0;
        end else begin
            for (int i = 0; i < NSEL; i++) begin
                if (sel_hit[i] && (sel_val != SEL_BAD)) sel_codes[i] <= sel_val;
            end
            if (logic_hit && !logic_bad) neg <= (ch == "N");
        end
    end

endmodule

// File: rtl/romcard_data.sv
// Data card decoder. It collects the start address digits and then the
// word digits, checks the format, and issues one write per completed word.
// Errors are sticky and block all later writes. Assumes DATA_W >= 4 and
// that step is low in the cycle after a write (the top holds ready low).
module romcard_data #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int WORDS       = 16,
    parameter int ADDR_DIGITS = 4,
    parameter int COL_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [7:0]        ch,
    input  logic [COL_W-1:0]  col,
    input  logic              data_card,
    input  logic              hdr_err,
    input  logic              neg,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err
);
    import romcard_pkg::*;

    localparam int WORD_DIGITS = (DATA_W + 2) / 3;
    localparam int ACC_W       = 3 * WORD_DIGITS;
    localparam int AACC_W      = 3 * ADDR_DIGITS;
    localparam int IDX_W       = $clog2(WORDS);
    localparam int DIG_W       = (WORD_DIGITS > 1) ? $clog2(WORD_DIGITS) : 1;
    localparam logic [COL_W-1:0] ADDR_END = COL_W'(ADDR_DIGITS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(ADDR_DIGITS + WORD_DIGITS * WORDS);
    localparam logic [DIG_W-1:0] DIG_LAST = DIG_W'(WORD_DIGITS - 1);

    oct_t              od;
    logic              is_lf, in_addr, in_words, last_dig;
    logic [AACC_W-1:0] addr_acc, addr_next;
    logic [ACC_W-1:0]  word_acc, word_next;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  widx;
    logic [DIG_W-1:0]  dig;
    logic              addr_bad, word_ovf, char_bad, fmt_bad, err_set, do_write;

    // Classify the current byte and form the shifted accumulators
    always_comb begin
        od        = oct_decode(ch);
        is_lf     = (ch == CH_LF);
        in_addr   = (col <= ADDR_END);
        in_words  = (col > ADDR_END) && (col <= LAST_COL);
        last_dig  = (dig == DIG_LAST);
        addr_next = {addr_acc[AACC_W-4:0], od.val};
        word_next = {word_acc[ACC_W-4:0], od.val};
        addr_bad  = (addr_next[IDX_W-1:0] != '0) || ((addr_next >> ADDR_W) != '0);
        word_ovf  = ((word_next >> DATA_W) != '0);
        char_bad  = !is_lf && (in_addr || in_words) && !od.ok;
        fmt_bad   = step && data_card &&
                    (char_bad ||
                     (!is_lf && od.ok && (col == ADDR_END) && addr_bad) ||
                     (!is_lf && od.ok && in_words && last_dig && word_ovf) ||
                     (is_lf && (col <= LAST_COL)));
        err_set   = fmt_bad || hdr_err;
        do_write  = step && data_card && !is_lf && in_words && od.ok &&
                    last_dig && !word_ovf && !err;
    end

    // Sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (err_set) err <= 1'b1;
    end

    // Write strobe, address and data, registered once per completed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= do_write;
            if (do_write) begin
                wr_addr <= base + ADDR_W'(widx);
                wr_data <= neg ? ~word_next[DATA_W-1:0] : word_next[DATA_W-1:0];
            end
        end
    end

    // Digit accumulation and word position within the card
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_acc <= '0;
            word_acc <= '0;
            base     <= '0;
            widx     <= '0;
            dig      <= '0;
        end else if (step && data_card) begin
            if (is_lf) begin
                widx <= '0;
                dig  <= '0;
            end else if (od.ok) begin
                if (in_addr) addr_acc <= addr_next;
                if (in_addr && (col == ADDR_END)) base <= addr_next[ADDR_W-1:0];
                if (in_words) begin
                    word_acc <= word_next;
                    if (last_dig) begin
                        dig  <= '0;
                        widx <= widx + 1'b1;
                    end else begin
                        dig <= dig + 1'b1;
                    end
                end
            end
        end
    end

    // R4: the write strobe lasts exactly one cycle
    p_wr_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en)
        else $error("write strobe longer than one cycle");

    // R7: the error flag never clears
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err)
        else $error("error flag cleared");

    // R7: no write while the error flag is set
    p_no_wr_after_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !wr_en)
        else $error("write after error");

endmodule

// File: rtl/romcard_loader.sv
// Top of the card-image ROM loader. It joins the column tracker, the
// header capture and the data decoder, handles the byte handshake, and
// gates the header results onto the outputs once loading is done.
// Assumes the memory port accepts a write in any cycle.
module romcard_loader #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int WORDS       = 16,
    parameter int ADDR_DIGITS = 4,
    parameter int HDR_CARDS   = 4,
    parameter int COL_W       = 7,
    parameter int SEL_CARD    = 3,
    parameter int SEL_COL0    = 33,
    parameter int SEL_STEP    = 2,
    parameter int LOGIC_CARD  = 4,
    parameter int LOGIC_COL   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              err,
    output logic [1:0]        sel1_code,
    output logic [1:0]        sel2_code,
    output logic [1:0]        sel3_code,
    output logic              neg_logic
);
    import romcard_pkg::*;

    localparam int NSEL        = 3;
    localparam int DATA_CARDS  = (2 ** ADDR_W) / WORDS;
    localparam int TOTAL_CARDS = HDR_CARDS + DATA_CARDS;
    localparam int CARD_W      = $clog2(TOTAL_CARDS + 1);

    logic                 step, is_lf, data_card, hdr_err, neg;
    logic [COL_W-1:0]     col;
    logic [CARD_W-1:0]    card;
    logic [NSEL-1:0][1:0] sel_codes;

    // Hold off input while a write is in flight; after done, accept and drop
    assign in_ready = !wr_en;
    assign step     = in_valid && in_ready && !done;
    assign is_lf    = (in_data == CH_LF);

    romcard_track #(
        .COL_W(COL_W), .HDR_CARDS(HDR_CARDS), .TOTAL_CARDS(TOTAL_CARDS)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .step(step), .is_lf(is_lf),
        .col(col), .card(card), .data_card(data_card), .all_done(done)
    );

    romcard_hdr #(
        .COL_W(COL_W), .CARD_W(CARD_W), .NSEL(NSEL), .SEL_CARD(SEL_CARD),
        .SEL_COL0(SEL_COL0), .SEL_STEP(SEL_STEP),
        .LOGIC_CARD(LOGIC_CARD), .LOGIC_COL(LOGIC_COL)
    ) u_hdr (
        .clk(clk), .rst_n(rst_n), .step(step), .is_lf(is_lf), .ch(in_data),
        .col(col), .card(card), .sel_codes(sel_codes), .neg(neg),
        .hdr_err(hdr_err)
    );

    romcard_data #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
        .ADDR_DIGITS(ADDR_DIGITS), .COL_W(COL_W)
    ) u_data (
        .clk(clk), .rst_n(rst_n), .step(step), .ch(in_data), .col(col),
        .data_card(data_card), .hdr_err(hdr_err), .neg(neg),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err(err)
    );

    // Header results are shown only after the last data card
    assign sel1_code = done ? sel_codes[0] : 2'b00;
    assign sel2_code = done ? sel_codes[1] : 2'b00;
    assign sel3_code = done ? sel_codes[2] : 2'b00;
    assign neg_logic = done && neg;

    // R5: every write follows a byte that was offered and accepted
    p_wr_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid && in_ready))
        else $error("write without an accepted byte");

    // R11: header outputs hold still once done
    p_codes_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable({sel1_code, sel2_code, sel3_code, neg_logic}))
        else $error("header outputs changed after done");

endmodule

// File: tb/romcard_loader_test.sv
`timescale 1ns/100ps
module romcard_loader_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, wr_en, done, err, neg_logic;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  sel1_code, sel2_code, sel3_code;

    int checks = 0;
    int errors = 0;
    int got_cnt = 0;
    bit prev_wr = 1'b0;
    int pulse_viol = 0;
    logic [7:0] got_mem [2048];
    logic [7:0] exp_mem [2048];
    int card_w [16];

    always #2.5 clk = ~clk;

    romcard_loader uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .err(err), .sel1_code(sel1_code),
        .sel2_code(sel2_code), .sel3_code(sel3_code), .neg_logic(neg_logic)
    );

    // Record writes away from the active edge
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            got_mem[wr_addr] = wr_data;
            got_cnt++;
            if (prev_wr) pulse_viol++;
        end
        prev_wr = rst_n && wr_en;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string oct_str(input int v, input int n);
        string s = "";
        for (int i = n - 1; i >= 0; i--) s = $sformatf("%s%0d", s, (v >> (3 * i)) & 7);
        return s;
    endfunction

    function automatic string data_line(input int addr);
        string s = oct_str(addr, 4);
        for (int j = 0; j < 16; j++) s = {s, oct_str(card_w[j], 3)};
        return s;
    endfunction

    function automatic string fill(input int n);
        string s = "";
        repeat (n) s = {s, "A"};
        return s;
    endfunction

    function automatic int sel_exp(input byte c);
        return (c == "0") ? 0 : (c == "1") ? 1 : 2;
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge
    task automatic send_byte(input logic [7:0] c);
        in_data  = c;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_line(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        send_byte(8'h0A);
    endtask

    task automatic send_header(input byte c1, input byte c2, input byte c3, input byte lg);
        send_line("HEADER CARD ONE");
        send_line("HEADER CARD TWO");
        send_line($sformatf("%s%c %c %c", fill(32), c1, c2, c3));
        send_line($sformatf("%s%c", fill(14), lg));
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 2048; i++) begin
            got_mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        got_cnt = 0;
        @(negedge clk);
    endtask

    // Full image load with permuted card order
    task automatic full_run(input byte c1, input byte c2, input byte c3, input byte lg, input int stride);
        bit neg = (lg == "N");
        string s;
        int mm = 0;
        do_reset();
        send_header(c1, c2, c3, lg);
        for (int k = 0; k < 128; k++) begin
            int addr = ((k * stride) % 128) * 16;
            for (int j = 0; j < 16; j++) begin
                card_w[j] = (k == 0 && j == 0) ? 8'o245 : int'($urandom_range(0, 255));
                exp_mem[addr + j] = neg ? ~8'(card_w[j]) : 8'(card_w[j]);
            end
            s = data_line(addr);
            if (k % 5 == 0) s = {s, "ZZ9x"};   // R8: beyond column 52, ignored
            for (int i = 0; i < s.len(); i++) begin
                send_byte(s[i]);
                if (k == 0 && i == 6) begin
                    check_eq("R4", "wr_en after third digit", int'(wr_en), 1);
                    check_eq("R5", "ready during write", int'(in_ready), 0);
                    check_eq("R4", "first word address", int'(wr_addr), addr);
                    check_eq("R10", "first word data", int'(wr_data), int'(exp_mem[addr]));
                    @(negedge clk);
                    check_eq("R4", "strobe one cycle", int'(wr_en), 0);
                    check_eq("R5", "ready after write", int'(in_ready), 1);
                end
            end
            if (k == 127) begin
                check_eq("R11", "done before last LF", int'(done), 0);
                check_eq("R11", "codes hidden before done",
                         int'({sel1_code, sel2_code, sel3_code, neg_logic}), 0);
            end
            send_byte(8'h0A);
        end
        for (int i = 0; i < 2048; i++) if (got_mem[i] !== exp_mem[i]) mm++;
        check_eq("R4", "image mismatches", mm, 0);
        check_eq("R4", "write count", got_cnt, 2048);
        check_eq("R2", "no error on good deck", int'(err), 0);
        check_eq("R11", "done after last card", int'(done), 1);
        check_eq("R9", "select one code", int'(sel1_code), sel_exp(c1));
        check_eq("R9", "select two code", int'(sel2_code), sel_exp(c2));
        check_eq("R9", "select three code", int'(sel3_code), sel_exp(c3));
        check_eq("R10", "logic sense", int'(neg_logic), int'(neg));
        for (int j = 0; j < 16; j++) card_w[j] = j;
        send_line(data_line(0));
        check_eq("R11", "no writes after done", got_cnt, 2048);
        check_eq("R11", "ready after done", int'(in_ready), 1);
        check_eq("R11", "done holds", int'(done), 1);
    endtask

    // One malformed deck, then a good card that must not be written
    task automatic err_case(input string req, input byte c1, input byte lg,
                            input string line, input int exp_writes);
        do_reset();
        send_header(c1, "1", "0", lg);
        send_line(line);
        check_eq(req, "error flag", int'(err), 1);
        check_eq(req, "writes before error", got_cnt, exp_writes);
        for (int j = 0; j < 16; j++) card_w[j] = j + 1;
        send_line(data_line(16));
        check_eq("R7", "no writes after error", got_cnt, exp_writes);
        check_eq("R7", "error stays set", int'(err), 1);
    endtask

    initial begin
        string s;
        void'($urandom(32'h0005EED5));
        do_reset();
        check_eq("R1", "ready", int'(in_ready), 1);
        check_eq("R1", "outputs idle",
                 int'({wr_en, done, err, sel1_code, sel2_code, sel3_code, neg_logic}), 0);

        full_run("1", "0", "2", "P", 37);
        full_run("2", "1", "0", "N", 91);

        for (int j = 0; j < 16; j++) card_w[j] = j;
        err_case("R3", "1", "P", data_line(1), 0);          // misaligned address
        err_case("R3", "1", "P", data_line(2048), 0);       // octal 4000, out of range
        card_w[0] = 1; card_w[1] = 2; card_w[2] = 256;      // octal 400
        err_case("R6", "1", "P", data_line(64), 2);
        check_eq("R6", "word 0 kept", int'(got_mem[64]), 1);
        check_eq("R6", "word 1 kept", int'(got_mem[65]), 2);
        check_eq("R6", "word 2 dropped", int'(got_mem[66]), 0);
        for (int j = 0; j < 16; j++) card_w[j] = 7;
        s = data_line(128);
        s.putc(8, "x");                                     // second word, middle digit
        err_case("R6", "1", "P", s, 1);
        s = data_line(128);
        s.putc(1, "8");                                     // address digit
        err_case("R6", "1", "P", s, 0);
        err_case("R8", "1", "P", data_line(0).substr(0, 18), 5);
        err_case("R9", "3", "P", data_line(0), 0);
        err_case("R10", "1", "Q", data_line(0), 0);

        check_eq("R4", "strobe pulse violations", pulse_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule